// File: doc/BRIEF.md
# Latched Status Register Bank with Parity

This block keeps a small bank of status registers that record error events raised by logic inside the chip. Each register holds seven sticky event bits. The serial read path sees each register as one byte, with a parity bit in the top position. An active-low error output summarises the whole bank: it is low while any recorded bit is set.

Status contents and the error output change only while the serial chip select is idle (high). Events that arrive during a transfer are held in a pending stage. They are folded into the registers on the first clock with chip select high, so a byte read early in a transfer can show an older status.

The serial slave reports each decoded command through a one-cycle strobe, which carries whether the command was a read and its address. A register is cleared only when the last command of a transfer was a read of that register and chip select then rises. Chip select is expected to be synchronous to `clk` already.

Top module: `stat_latch_bank`

## Requirements
- R1: After reset every status byte reads 0x00 and `err_n_o` is high.
- R2: An event bit `evt_i[N*7+b]` that is high at a clock edge with chip select high sets bit b of register N. The bit stays set until that register is cleared.
- R3: Register N appears as `stat_o[N*8 +: 8]`. Bits 6:0 are the latched events and bit 7 is their parity: 1 for an odd count of ones, 0 for an even count.
- R4: While `cs_n_i` is low, `stat_o` and `err_n_o` do not change, even when events arrive.
- R5: Events raised while `cs_n_i` is low are held pending and appear in the registers after the first clock edge with `cs_n_i` high.
- R6: A clear happens when the last command strobe during a low phase of `cs_n_i` is a read (`cmd_rd_i`=1) of register N, and `cs_n_i` then rises. The clear takes effect on that first high clock and leaves only events that were pending from the transfer.
- R7: `err_n_o` is low exactly when some latched status bit is set. It changes on the same edge as the status bytes.
- R8: A rise of `cs_n_i` clears nothing in three cases: when the last command was a write, when it addressed a number at or above the register count, or for any register other than the one read.
- R9: An event that is high on the clearing edge does not block the clear. It re-latches on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Serial chip select, active low, synchronous to clk |
| cmd_vld_i | input | 1 | One-cycle strobe: a command byte was decoded |
| cmd_rd_i | input | 1 | Decoded command is a read (1) or a write (0) |
| cmd_addr_i | input | ADDR_W | Register address of the decoded command |
| evt_i | input | NUM_REGS*7 | Error event inputs, seven per register |
| stat_o | output | NUM_REGS*8 | Status bytes with parity in bit 7 |
| err_n_o | output | 1 | Active-low summary error flag |

## Verification
The bench raises events inside a transfer and checks that nothing moves until chip select rises. A design without freezing would show the new byte early, and one that dropped pending events would never show it. It places a write, or a read of an unused address, after a valid read. This catches a design that clears on any read in the packet rather than the last command. It raises an event on the very edge of a clear: a design that let the event mask the clear keeps the bit and error low. The bench also fills a register with seven ones and checks odd parity against even patterns, which catches an inverted or truncated parity tree.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int STAT_W = 7;
  localparam int BYTE_W = STAT_W + 1;

  function automatic logic odd_ones(input logic [STAT_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/stat_clr_arm.sv
// Remembers whether the last command of the current transfer was a read of
// a status register, and which one; presents a per-register clear request.
module stat_clr_arm
  import stat_bank_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_hi_i,
  input  logic                cs_rise_i,
  input  logic                cmd_vld_i,
  input  logic                cmd_rd_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  output logic [NUM_REGS-1:0] clr_o
);
  localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic              arm_q, arm_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              cmd_take;

  assign cmd_take = cmd_vld_i && !cs_hi_i;

  always_comb begin
    arm_d = arm_q;
    idx_d = idx_q;
    if (cs_hi_i) begin
      arm_d = 1'b0;
    end else if (cmd_take) begin
      arm_d = cmd_rd_i && ({1'b0, cmd_addr_i} < ADDR_LIMIT);
      idx_d = cmd_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      idx_q <= '0;
    end else begin
      arm_q <= arm_d;
      idx_q <= idx_d;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_clr
    assign clr_o[i] = arm_q && (idx_q == ADDR_W'(i));
  end

  // R6/R8: at most one register is ever asked to clear
  assert_one_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
  // R8: a write strobe inside a transfer disarms any clear
  assert_write_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && !cmd_rd_i) |=> (clr_o == '0));
  // cs_rise_i is only a hint here; the arm is dropped once chip select is high
  assert_arm_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i) |=> (clr_o == '0));
endmodule

// File: rtl/stat_cell.sv
// One status register: sticky event bits plus the pending stage for events
// that arrive while chip select is low.
module stat_cell
  import stat_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi_i,
  input  logic              cs_rise_i,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] evt_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] stat_nxt_o
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [STAT_W-1:0] pend_q, pend_d;
  logic              stat_en;

  assign stat_en = cs_hi_i;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    if (!cs_hi_i) begin
      pend_d = pend_q | evt_i;
    end else if (cs_rise_i) begin
      // clearing edge: merge only the transfer's pending events; live
      // events wait one cycle in the pending stage
      stat_d = (clr_i ? '0 : stat_q) | pend_q;
      pend_d = evt_i;
    end else begin
      stat_d = stat_q | pend_q | evt_i;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign stat_o     = stat_q;
  assign stat_nxt_o = stat_en ? stat_d : stat_q;

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hi_i |=> $stable(stat_q));
  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_i && !cs_rise_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && clr_i) |=> ((stat_q & ~$past(pend_q)) == '0));
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && !clr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/stat_byte_fmt.sv
// Packs seven status bits and their parity into the read byte.
module stat_byte_fmt
  import stat_bank_pkg::*;
(
  input  logic [STAT_W-1:0] bits_i,
  output logic [BYTE_W-1:0] byte_o
);
  assign byte_o = {odd_ones(bits_i), bits_i};
endmodule

// File: rtl/stat_latch_bank.sv
module stat_latch_bank
  import stat_bank_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int ADDR_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n_i,
  input  logic                       cmd_vld_i,
  input  logic                       cmd_rd_i,
  input  logic [ADDR_W-1:0]          cmd_addr_i,
  input  logic [NUM_REGS*STAT_W-1:0] evt_i,
  output logic [NUM_REGS*BYTE_W-1:0] stat_o,
  output logic                       err_n_o
);
  localparam int ALL_W = NUM_REGS * STAT_W;

  logic [1:0]          rst_sync_q;
  logic                rst_s_n;
  logic                cs_q;
  logic                cs_hi, cs_rise;
  logic [NUM_REGS-1:0] clr;
  logic [ALL_W-1:0]    stat_all, stat_nxt_all;
  logic                err_n_q, err_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cs_q <= 1'b1;
    end else begin
      cs_q <= cs_n_i;
    end
  end
  assign cs_hi   = cs_n_i;
  assign cs_rise = cs_n_i && !cs_q;

  stat_clr_arm #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_arm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cs_hi_i    (cs_hi),
    .cs_rise_i  (cs_rise),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_rd_i   (cmd_rd_i),
    .cmd_addr_i (cmd_addr_i),
    .clr_o      (clr)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    stat_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .cs_hi_i    (cs_hi),
      .cs_rise_i  (cs_rise),
      .clr_i      (clr[r]),
      .evt_i      (evt_i[r*STAT_W +: STAT_W]),
      .stat_o     (stat_all[r*STAT_W +: STAT_W]),
      .stat_nxt_o (stat_nxt_all[r*STAT_W +: STAT_W])
    );
    stat_byte_fmt u_fmt (
      .bits_i (stat_all[r*STAT_W +: STAT_W]),
      .byte_o (stat_o[r*BYTE_W +: BYTE_W])
    );
  end

  assign err_n_d = ~(|stat_nxt_all);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      err_n_q <= 1'b1;
    end else if (cs_hi) begin
      err_n_q <= err_n_d;
    end
  end
  assign err_n_o = err_n_q;

  assert_err_tracks_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_n_o == (stat_all == '0));
  assert_err_frozen_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cs_hi |=> $stable(err_n_o));
endmodule

// File: tb/stat_latch_bank_tb_top.sv
module stat_latch_bank_tb_top;
  localparam int NREG = 2;
  localparam int AW   = 2;

  typedef struct {
    string      tag;
    logic [15:0] stat;
    logic        err_n;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cs_n = 1'b1;
  logic            cmd_vld = 1'b0;
  logic            cmd_rd = 1'b0;
  logic [AW-1:0]   cmd_addr = '0;
  logic [13:0]     evt = '0;
  logic [15:0]     stat;
  logic            err_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  stat_latch_bank #(.NUM_REGS(NREG), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cmd_vld_i(cmd_vld),
    .cmd_rd_i(cmd_rd), .cmd_addr_i(cmd_addr), .evt_i(evt),
    .stat_o(stat), .err_n_o(err_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input string tag, input logic [15:0] s, input logic e);
    exp_t it;
    it.tag = tag; it.stat = s; it.err_n = e;
    q.push_back(it);
  endtask

  task automatic command(input logic rd, input logic [AW-1:0] a);
    cmd_vld = 1'b1; cmd_rd = rd; cmd_addr = a;
    tick();
    cmd_vld = 1'b0;
  endtask

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (stat !== it.stat || err_n !== it.err_n) begin
          errors++;
          $display("FAIL %s stat=%h exp=%h err_n=%b exp=%b",
                   it.tag, stat, it.stat, err_n, it.err_n);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    expect_now("R1 reset", 16'h0000, 1'b1);

    evt[0] = 1'b1; tick(); evt = '0;
    expect_now("R2 R3 R7 odd parity", 16'h0081, 1'b0);
    evt[1] = 1'b1; tick(); evt = '0;
    expect_now("R3 even parity", 16'h0003, 1'b0);
    repeat (3) tick();
    expect_now("R2 sticky", 16'h0003, 1'b0);

    cs_n = 1'b0; tick();
    evt[7+2] = 1'b1; tick(); evt = '0; tick();
    expect_now("R4 frozen stat", 16'h0003, 1'b0);
    cs_n = 1'b1; tick();
    expect_now("R5 R8 pending merged no clear", 16'h8403, 1'b0);

    cs_n = 1'b0; tick();
    command(1'b1, 2'd0); tick();
    cs_n = 1'b1; tick();
    expect_now("R6 clear reg0", 16'h8400, 1'b0);

    cs_n = 1'b0; tick();
    command(1'b1, 2'd1); command(1'b0, 2'd1);
    cs_n = 1'b1; tick();
    expect_now("R8 write last", 16'h8400, 1'b0);

    cs_n = 1'b0; tick();
    command(1'b1, 2'd1); command(1'b1, 2'd3);
    cs_n = 1'b1; tick();
    expect_now("R8 out of range", 16'h8400, 1'b0);

    cs_n = 1'b0; tick();
    command(1'b1, 2'd1);
    cs_n = 1'b1; tick();
    expect_now("R6 R7 clear reg1 err high", 16'h0000, 1'b1);

    cs_n = 1'b0; tick();
    evt[6] = 1'b1; tick(); evt = '0; tick();
    expect_now("R4 frozen err", 16'h0000, 1'b1);
    cs_n = 1'b1; tick();
    expect_now("R5 R7 merge on rise", 16'h00C0, 1'b0);

    cs_n = 1'b0; tick();
    command(1'b1, 2'd0);
    cs_n = 1'b1; evt[6] = 1'b1; tick();
    expect_now("R9 R6 clear wins edge", 16'h0000, 1'b1);
    tick();
    expect_now("R9 relatch", 16'h00C0, 1'b0);
    evt = '0; tick();

    evt[13:7] = 7'h7F; tick(); evt = '0;
    expect_now("R3 seven ones", 16'hFFC0, 1'b0);
    evt[5:0] = 6'h3F; tick(); evt = '0;
    expect_now("R3 R2 full reg0", 16'hFFFF, 1'b0);

    repeat (3) tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule